// File: doc/BRIEF.md
# UART Host Register Bank with Hidden Extended Bank

This block is the host-side register file of a UART. A simple bus, made of an address, a read strobe, a write strobe and a data byte, reaches the character format register and the two bytes of the baud divisor. It also reaches a hidden bank that holds a feature-control byte and two pairs of flow-control characters. The block drives the settings it holds straight to the serial engines. It forwards receive-buffer pops and transmit loads as single-cycle pulses, and it builds a line status byte from events that the receiver reports.

The format register has one bit that selects an alternate map for the low addresses. It also has one reserved write value, the key 0xBF. Writing the key opens the hidden bank and sets the alternate-map bit, but it leaves the seven format bits alone, so the serial framing in use does not change. Writing any other value to the format register stores that value and closes the hidden bank. Reads are combinational and return data in the same cycle as the strobe. Writes and flag updates take effect at the next rising clock edge.

Top module: `uart_regbank`

## Requirements
- R1: After reset the format register reads 0x03, both divisor bytes and all hidden-bank bytes are 0, the hidden bank is closed, and the overrun and parity flags are clear.
- R2: Writing 0xBF to the format register (address 3) sets its bit 7 and opens the hidden bank. Bits 6:0, and therefore the `fmt_cfg` output, keep their previous value.
- R3: Writing any value other than 0xBF to address 3 stores all eight bits and closes the hidden bank. A read of address 3 always returns the stored byte.
- R4: While format bit 7 is 0, a read of address 0 returns `rx_data` and pulses `rhr_pop`, and a write to address 0 pulses `thr_load` with `thr_data` equal to the written byte. A read of address 1 returns 0.
- R5: While the hidden bank is open, address 2 maps to the feature byte, 4 to XON1, 5 to XON2, 6 to XOFF1 and 7 to XOFF2. While it is closed, writes to addresses 2, 4, 6 and 7 are ignored and reads of those addresses return 0.
- R6: With the hidden bank closed, address 5 reads as the status byte. Bit 0 is `rx_avail`, bit 1 is the overrun flag, bit 2 is the parity flag, bit 5 is `tx_thr_empty` and bit 6 is `tx_idle`. All other bits are 0.
- R7: A pulse on `rx_overrun` sets the overrun flag. A status read clears the flag at the next edge, unless a set pulse arrives in the same cycle, in which case the flag stays set.
- R8: A pulse on `rx_head_new` while `rx_head_perr` is 1 sets the parity flag. A status read clears the flag, and a set in the same cycle wins over the clear.
- R9: While the hidden bank is open, reading address 5 returns XON2 and leaves the overrun and parity flags unchanged.
- R10: While format bit 7 is 1, whether set by an ordinary write or by the key, addresses 0 and 1 reach the low and high divisor bytes. In this map `rhr_pop` and `thr_load` do not pulse, and `divisor` equals {high, low}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 when no read is active |
| rx_data | input | 8 | Character at the head of the receive buffer |
| rx_avail | input | 1 | Receive buffer holds data |
| rx_head_new | input | 1 | Pulse: a new character reached the buffer head |
| rx_head_perr | input | 1 | Parity error or ninth bit of the head character |
| rx_overrun | input | 1 | Pulse: a character arrived while the buffer was full |
| tx_thr_empty | input | 1 | Transmit holding register empty |
| tx_idle | input | 1 | Transmitter completely idle |
| rhr_pop | output | 1 | Pulse: host read the receive character |
| thr_load | output | 1 | Pulse: host wrote a transmit character |
| thr_data | output | 8 | Transmit character |
| fmt_cfg | output | 7 | Active character format (format register bits 6:0) |
| divisor | output | 16 | Baud divisor {high, low} |
| efr | output | 8 | Feature-control byte |
| xon1 | output | 8 | First XON character |
| xon2 | output | 8 | Second XON character |
| xoff1 | output | 8 | First XOFF character |
| xoff2 | output | 8 | Second XOFF character |

## Verification
If the hidden-bank state bit were wrong, the fault would appear on the next host access to addresses 2, 4, 5, 6 or 7. Such a read would return 0 or the status byte where a flow-control character was expected, or the reverse. If the key write disturbed the format bits, `fmt_cfg` would change one cycle after the write. If a status flag set or cleared wrongly, address 5 would read a different value on the very next status read. A read of XON2 that wrongly cleared a flag would be visible as soon as the bank closes. A random mix of bus traffic, with the key written often and receiver events injected alongside, is compared every cycle against a bench model of these rules.

// File: rtl/urb_pkg.sv
package urb_pkg;

    // Fixed address map (3-bit address space)
    localparam logic [2:0] ADR_DATA  = 3'd0;
    localparam logic [2:0] ADR_HIGH  = 3'd1;
    localparam logic [2:0] ADR_FEAT  = 3'd2;
    localparam logic [2:0] ADR_FMT   = 3'd3;
    localparam logic [2:0] ADR_XON1  = 3'd4;
    localparam logic [2:0] ADR_STAT  = 3'd5;
    localparam logic [2:0] ADR_XOFF1 = 3'd6;
    localparam logic [2:0] ADR_XOFF2 = 3'd7;

    // Status byte bit positions
    localparam int ST_AVAIL = 0;
    localparam int ST_OVR   = 1;
    localparam int ST_PERR  = 2;
    localparam int ST_TEMPT = 5;
    localparam int ST_TIDLE = 6;

    // Index of each stored configuration byte
    typedef enum logic [2:0] {
        CFG_DLL   = 3'd0,
        CFG_DLM   = 3'd1,
        CFG_EFR   = 3'd2,
        CFG_XON1  = 3'd3,
        CFG_XON2  = 3'd4,
        CFG_XOFF1 = 3'd5,
        CFG_XOFF2 = 3'd6
    } cfg_idx_e;

    localparam int NCFG = 7;

    // Result of address decoding
    typedef struct packed {
        logic     fmt;
        logic     stat;
        logic     rhr;
        logic     thr;
        logic     cfg;
        cfg_idx_e idx;
    } sel_t;

    function automatic sel_t decode(input logic [2:0] adr,
                                    input logic dlab,
                                    input logic ext);
        sel_t s;
        s.fmt  = 1'b0;
        s.stat = 1'b0;
        s.rhr  = 1'b0;
        s.thr  = 1'b0;
        s.cfg  = 1'b0;
        s.idx  = CFG_DLL;
        unique case (adr)
            ADR_DATA: begin
                if (dlab) begin
                    s.cfg = 1'b1;
                    s.idx = CFG_DLL;
                end else begin
                    s.rhr = 1'b1;
                    s.thr = 1'b1;
                end
            end
            ADR_HIGH: begin
                s.cfg = dlab;
                s.idx = CFG_DLM;
            end
            ADR_FEAT: begin
                s.cfg = ext;
                s.idx = CFG_EFR;
            end
            ADR_FMT: s.fmt = 1'b1;
            ADR_XON1: begin
                s.cfg = ext;
                s.idx = CFG_XON1;
            end
            ADR_STAT: begin
                s.cfg  = ext;
                s.stat = !ext;
                s.idx  = CFG_XON2;
            end
            ADR_XOFF1: begin
                s.cfg = ext;
                s.idx = CFG_XOFF1;
            end
            default: begin
                s.cfg = ext;
                s.idx = CFG_XOFF2;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/urb_fmt_reg.sv
module urb_fmt_reg #(
    parameter int            DW        = 8,
    parameter logic [DW-1:0] RESET_VAL = 8'h03,
    parameter logic [DW-1:0] KEY       = 8'hBF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] fmt_q,
    output logic          ext_q
);

    localparam int TOP = DW - 1;

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= RESET_VAL;
            ext_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_data == KEY) begin
                fmt_q[TOP] <= 1'b1;
                ext_q      <= 1'b1;
            end else begin
                fmt_q <= wr_data;
                ext_q <= 1'b0;
            end
        end
    end

    // R2: key write keeps the low format bits and opens the bank
    a_r2_key_keeps_format: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data == KEY) |=>
            (fmt_q[TOP-1:0] == $past(fmt_q[TOP-1:0]) && fmt_q[TOP] && ext_q));

    // R3: any other write stores the whole byte and closes the bank
    a_r3_plain_write_exits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data != KEY) |=> (!ext_q && fmt_q == $past(wr_data)));

    // R10: an open hidden bank always comes with the alternate map
    a_r10_ext_implies_dlab: assert property (@(posedge clk) disable iff (rst)
        ext_q |-> fmt_q[TOP]);

endmodule

// File: rtl/urb_cfg_store.sv
module urb_cfg_store #(
    parameter int DW = 8,
    parameter int N  = 7
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          wr_en,
    input  logic [DW-1:0]         wr_data,
    output logic [N-1:0][DW-1:0]  regs_q
);

    for (genvar i = 0; i < N; i++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[i] <= '0;
            end else if (wr_en[i]) begin
                regs_q[i] <= wr_data;
            end
        end
    end

    // R5: decoding never selects two stored bytes at once
    a_r5_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en));

endmodule

// File: rtl/urb_status.sv
module urb_status #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_clr,
    input  logic          ovr_evt,
    input  logic          head_new,
    input  logic          head_perr,
    input  logic          rx_avail,
    input  logic          thr_empty,
    input  logic          tx_idle,
    output logic [DW-1:0] stat_o
);

    import urb_pkg::*;

    logic ovr_q;
    logic perr_q;
    logic perr_set;

    assign perr_set = head_new & head_perr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q  <= 1'b0;
            perr_q <= 1'b0;
        end else begin
            if (ovr_evt) begin
                ovr_q <= 1'b1;
            end else if (rd_clr) begin
                ovr_q <= 1'b0;
            end
            if (perr_set) begin
                perr_q <= 1'b1;
            end else if (rd_clr) begin
                perr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        stat_o           = '0;
        stat_o[ST_AVAIL] = rx_avail;
        stat_o[ST_OVR]   = ovr_q;
        stat_o[ST_PERR]  = perr_q;
        stat_o[ST_TEMPT] = thr_empty;
        stat_o[ST_TIDLE] = tx_idle;
    end

    // R7: an overrun event always leaves the flag set
    a_r7_ovr_set_wins: assert property (@(posedge clk) disable iff (rst)
        ovr_evt |=> ovr_q);

    // R7: a status read without a new event clears the flag
    a_r7_ovr_read_clears: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && !ovr_evt) |=> !ovr_q);

    // R8: a flagged head character always leaves the flag set
    a_r8_perr_set_wins: assert property (@(posedge clk) disable iff (rst)
        (head_new && head_perr) |=> perr_q);

    // R8: the flag holds its value while nothing touches it
    a_r8_perr_holds: assert property (@(posedge clk) disable iff (rst)
        (!rd_clr && !head_new) |=> $stable(perr_q));

endmodule

// File: rtl/uart_regbank.sv
module uart_regbank #(
    parameter int          DW        = 8,
    parameter logic [7:0]  FMT_RESET = 8'h03,
    parameter logic [7:0]  EXT_KEY   = 8'hBF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      bus_addr,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic [DW-1:0]   rx_data,
    input  logic            rx_avail,
    input  logic            rx_head_new,
    input  logic            rx_head_perr,
    input  logic            rx_overrun,
    input  logic            tx_thr_empty,
    input  logic            tx_idle,
    output logic            rhr_pop,
    output logic            thr_load,
    output logic [DW-1:0]   thr_data,
    output logic [DW-2:0]   fmt_cfg,
    output logic [2*DW-1:0] divisor,
    output logic [DW-1:0]   efr,
    output logic [DW-1:0]   xon1,
    output logic [DW-1:0]   xon2,
    output logic [DW-1:0]   xoff1,
    output logic [DW-1:0]   xoff2
);

    import urb_pkg::*;

    localparam int TOP = DW - 1;

    logic [DW-1:0]           fmt_q;
    logic                    ext_q;
    logic [NCFG-1:0]         cfg_wr;
    logic [NCFG-1:0][DW-1:0] cfg_q;
    logic [DW-1:0]           stat_q;
    logic                    stat_clr;
    logic [DW-1:0]           rd_val;
    sel_t                    sel;

    assign sel      = decode(bus_addr, fmt_q[TOP], ext_q);
    assign stat_clr = bus_rd & sel.stat;
    assign rhr_pop  = bus_rd & sel.rhr;
    assign thr_load = bus_wr & sel.thr;
    assign thr_data = bus_wdata;

    for (genvar i = 0; i < NCFG; i++) begin : g_wr
        assign cfg_wr[i] = bus_wr & sel.cfg & (int'(sel.idx) == i);
    end

    urb_fmt_reg #(
        .DW        (DW),
        .RESET_VAL (DW'(FMT_RESET)),
        .KEY       (DW'(EXT_KEY))
    ) u_fmt (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (bus_wr & sel.fmt),
        .wr_data (bus_wdata),
        .fmt_q   (fmt_q),
        .ext_q   (ext_q)
    );

    urb_cfg_store #(
        .DW (DW),
        .N  (NCFG)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr),
        .wr_data (bus_wdata),
        .regs_q  (cfg_q)
    );

    urb_status #(
        .DW (DW)
    ) u_stat (
        .clk       (clk),
        .rst       (rst),
        .rd_clr    (stat_clr),
        .ovr_evt   (rx_overrun),
        .head_new  (rx_head_new),
        .head_perr (rx_head_perr),
        .rx_avail  (rx_avail),
        .thr_empty (tx_thr_empty),
        .tx_idle   (tx_idle),
        .stat_o    (stat_q)
    );

    always_comb begin
        rd_val = '0;
        if (sel.fmt) begin
            rd_val = fmt_q;
        end else if (sel.stat) begin
            rd_val = stat_q;
        end else if (sel.rhr) begin
            rd_val = rx_data;
        end else if (sel.cfg) begin
            rd_val = cfg_q[sel.idx];
        end
        bus_rdata = bus_rd ? rd_val : '0;
    end

    assign fmt_cfg = fmt_q[TOP-1:0];
    assign divisor = {cfg_q[CFG_DLM], cfg_q[CFG_DLL]};
    assign efr     = cfg_q[CFG_EFR];
    assign xon1    = cfg_q[CFG_XON1];
    assign xon2    = cfg_q[CFG_XON2];
    assign xoff1   = cfg_q[CFG_XOFF1];
    assign xoff2   = cfg_q[CFG_XOFF2];

    // R10: divisor bytes move only while the alternate map is selected
    a_r10_divisor_guarded: assert property (@(posedge clk) disable iff (rst)
        !fmt_q[TOP] |=> $stable(divisor));

    // R5: hidden bytes move only while the hidden bank is open
    a_r5_hidden_guarded: assert property (@(posedge clk) disable iff (rst)
        !ext_q |=> ($stable(efr) && $stable(xon1) && $stable(xon2)
                    && $stable(xoff1) && $stable(xoff2)));

endmodule

// File: tb/uart_regbank_tb.sv
module uart_regbank_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  bus_addr;
    logic        bus_wr, bus_rd;
    logic [7:0]  bus_wdata, bus_rdata;
    logic [7:0]  rx_data;
    logic        rx_avail, rx_head_new, rx_head_perr, rx_overrun;
    logic        tx_thr_empty, tx_idle;
    logic        rhr_pop, thr_load;
    logic [7:0]  thr_data;
    logic [6:0]  fmt_cfg;
    logic [15:0] divisor;
    logic [7:0]  efr, xon1, xon2, xoff1, xoff2;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    // model state
    logic [7:0] m_fmt;
    logic       m_ext;
    logic [7:0] m_cfg [7];
    logic       m_ovr, m_perr;

    always #5 clk = ~clk;

    uart_regbank u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_data(rx_data), .rx_avail(rx_avail), .rx_head_new(rx_head_new),
        .rx_head_perr(rx_head_perr), .rx_overrun(rx_overrun),
        .tx_thr_empty(tx_thr_empty), .tx_idle(tx_idle), .rhr_pop(rhr_pop),
        .thr_load(thr_load), .thr_data(thr_data), .fmt_cfg(fmt_cfg),
        .divisor(divisor), .efr(efr), .xon1(xon1), .xon2(xon2),
        .xoff1(xoff1), .xoff2(xoff2)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int hid_idx(input logic [2:0] a);
        case (a)
            3'd2: return 2;
            3'd4: return 3;
            3'd5: return 4;
            3'd6: return 5;
            3'd7: return 6;
            default: return -1;
        endcase
    endfunction

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_fmt[7] ? m_cfg[0] : rx_data;
            3'd1: return m_fmt[7] ? m_cfg[1] : 8'h00;
            3'd3: return m_fmt;
            3'd5: return m_ext ? m_cfg[4]
                       : {1'b0, tx_idle, tx_thr_empty, 2'b00, m_perr, m_ovr, rx_avail};
            default: return m_ext ? m_cfg[hid_idx(a)] : 8'h00;
        endcase
    endfunction

    function automatic string tag_for(input logic [2:0] a);
        if (a == 3'd3) return "R3";
        if (a == 3'd5) return m_ext ? "R9" : "R6";
        if (a <= 3'd1) return m_fmt[7] ? "R10" : "R4";
        return "R5";
    endfunction

    task automatic model_reset();
        m_fmt  = 8'h03;
        m_ext  = 1'b0;
        m_ovr  = 1'b0;
        m_perr = 1'b0;
        for (int i = 0; i < 7; i++) m_cfg[i] = 8'h00;
    endtask

    task automatic check_outs(input string req);
        chk(req, "fmt_cfg", 32'(fmt_cfg), 32'(m_fmt[6:0]));
        chk(req, "divisor", 32'(divisor), 32'({m_cfg[1], m_cfg[0]}));
        chk(req, "hidden", {efr, xon1, xon2, xoff1},
            {m_cfg[2], m_cfg[3], m_cfg[4], m_cfg[5]});
        chk(req, "xoff2", 32'(xoff2), 32'(m_cfg[6]));
    endtask

    // one bus cycle: drive at negedge, check combinational outputs, update model at posedge
    task automatic cycle(input string tag, input logic [2:0] a, input logic w,
                         input logic r, input logic [7:0] d, input logic ov,
                         input logic hn, input logic hp);
        logic exp_pop, exp_load, stat_rd, nxt_ovr, nxt_perr;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_rd = r; bus_wdata = d;
        rx_overrun = ov; rx_head_new = hn; rx_head_perr = hp;
        #1;
        check_outs(tag);
        if (r) chk(tag, "rdata", 32'(bus_rdata), 32'(exp_rd(a)));
        else   chk(tag, "rdata idle", 32'(bus_rdata), 32'h0);
        exp_pop  = r && a == 3'd0 && !m_fmt[7];
        exp_load = w && a == 3'd0 && !m_fmt[7];
        chk(tag, "rhr_pop", 32'(rhr_pop), 32'(exp_pop));
        chk(tag, "thr_load", 32'(thr_load), 32'(exp_load));
        if (exp_load) chk(tag, "thr_data", 32'(thr_data), 32'(d));
        @(posedge clk);
        stat_rd  = r && a == 3'd5 && !m_ext;
        nxt_ovr  = ov ? 1'b1 : (stat_rd ? 1'b0 : m_ovr);
        nxt_perr = (hn && hp) ? 1'b1 : (stat_rd ? 1'b0 : m_perr);
        if (w) begin
            if (a == 3'd3) begin
                if (d == 8'hBF) begin
                    m_fmt[7] = 1'b1;
                    m_ext    = 1'b1;
                end else begin
                    m_fmt = d;
                    m_ext = 1'b0;
                end
            end else if (a <= 3'd1) begin
                if (m_fmt[7]) m_cfg[a] = d;
            end else if (m_ext) begin
                m_cfg[hid_idx(a)] = d;
            end
        end
        m_ovr  = nxt_ovr;
        m_perr = nxt_perr;
    endtask

    task automatic idle(input string tag);
        cycle(tag, 3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nbad++;
            nchk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    end

    initial begin
        logic [2:0] a;
        logic       w, r;
        logic [7:0] d;
        void'($urandom(32'h5eed1234));
        rst = 1'b1;
        bus_addr = '0; bus_wr = 0; bus_rd = 0; bus_wdata = '0;
        rx_data = 8'h00; rx_avail = 0; rx_head_new = 0; rx_head_perr = 0;
        rx_overrun = 0; tx_thr_empty = 0; tx_idle = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        #1;
        chk("R1", "fmt reset", 32'(fmt_cfg), 32'h03);
        chk("R1", "divisor reset", 32'(divisor), 32'h0);
        chk("R1", "efr reset", 32'(efr), 32'h0);
        cycle("R1", 3'd3, 0, 1, 8'h00, 0, 0, 0);
        cycle("R1", 3'd5, 0, 1, 8'h00, 0, 0, 0);

        // R3: plain format write
        cycle("R3", 3'd3, 1, 0, 8'h1B, 0, 0, 0);
        cycle("R3", 3'd3, 0, 1, 8'h00, 0, 0, 0);
        #1 chk("R3", "fmt literal", 32'(fmt_cfg), 32'h1B);

        // R7: set overrun before entering the hidden bank
        cycle("R7", 3'd0, 0, 0, 8'h00, 1, 0, 0);

        // R2: key write keeps format
        cycle("R2", 3'd3, 1, 0, 8'hBF, 0, 0, 0);
        @(negedge clk);
        bus_rd = 1; bus_wr = 0; bus_addr = 3'd3;
        #1;
        chk("R2", "fmt read after key", 32'(bus_rdata), 32'h9B);
        chk("R2", "fmt_cfg after key", 32'(fmt_cfg), 32'h1B);
        bus_rd = 0;

        // R5 / R9: hidden bank access
        cycle("R5", 3'd2, 1, 0, 8'h10, 0, 0, 0);
        cycle("R5", 3'd2, 0, 1, 8'h00, 0, 0, 0);
        cycle("R9", 3'd5, 1, 0, 8'h13, 0, 0, 0);
        cycle("R9", 3'd5, 0, 1, 8'h00, 0, 0, 0);
        #1 chk("R9", "xon2 literal", 32'(xon2), 32'h13);
        cycle("R10", 3'd0, 1, 0, 8'h34, 0, 0, 0);

        // R3: exit bank, R9: overrun survived the XON2 read
        cycle("R3", 3'd3, 1, 0, 8'h03, 0, 0, 0);
        @(negedge clk);
        bus_rd = 1; bus_addr = 3'd5;
        #1 chk("R9", "overrun kept", 32'(bus_rdata[1]), 32'h1);
        bus_rd = 0;
        cycle("R5", 3'd2, 1, 0, 8'hEE, 0, 0, 0);
        cycle("R5", 3'd2, 0, 1, 8'h00, 0, 0, 0);
        #1 chk("R5", "efr untouched", 32'(efr), 32'h10);

        // R10: ordinary write with bit 7 reaches divisor
        cycle("R10", 3'd3, 1, 0, 8'h83, 0, 0, 0);
        cycle("R10", 3'd1, 1, 0, 8'h12, 0, 0, 0);
        cycle("R10", 3'd0, 0, 1, 8'h00, 0, 0, 0);
        #1 chk("R10", "divisor literal", 32'(divisor), 32'h1234);
        cycle("R3", 3'd3, 1, 0, 8'h03, 0, 0, 0);

        // R4: data path in normal map
        rx_data = 8'hA5;
        cycle("R4", 3'd0, 0, 1, 8'h00, 0, 0, 0);
        cycle("R4", 3'd0, 1, 0, 8'h5A, 0, 0, 0);
        cycle("R4", 3'd1, 0, 1, 8'h00, 0, 0, 0);

        // R7: read plus set in same cycle keeps flag, then read clears
        cycle("R7", 3'd5, 0, 1, 8'h00, 1, 0, 0);
        cycle("R7", 3'd5, 0, 1, 8'h00, 0, 0, 0);
        cycle("R7", 3'd5, 0, 1, 8'h00, 0, 0, 0);
        #1 chk("R7", "overrun cleared", 32'(bus_rdata), 32'h0);
        // R8: parity flag rules
        cycle("R8", 3'd0, 0, 0, 8'h00, 0, 1, 0);
        cycle("R8", 3'd0, 0, 0, 8'h00, 0, 1, 1);
        cycle("R8", 3'd5, 0, 1, 8'h00, 0, 1, 1);
        cycle("R8", 3'd5, 0, 1, 8'h00, 0, 0, 0);
        cycle("R8", 3'd5, 0, 1, 8'h00, 0, 0, 0);
        // R6: status level bits
        rx_avail = 1; tx_thr_empty = 1; tx_idle = 1;
        cycle("R6", 3'd5, 0, 1, 8'h00, 0, 0, 0);
        rx_avail = 0; tx_idle = 0;
        cycle("R6", 3'd5, 0, 1, 8'h00, 0, 0, 0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            a = 3'($urandom_range(0, 7));
            w = ($urandom_range(0, 1) == 1);
            r = !w && ($urandom_range(0, 3) != 0);
            d = 8'($urandom);
            if (w && a == 3'd3 && $urandom_range(0, 9) < 4) d = 8'hBF;
            rx_data      = 8'($urandom);
            rx_avail     = 1'($urandom);
            tx_thr_empty = 1'($urandom);
            tx_idle      = 1'($urandom);
            cycle(tag_for(a), a, w, r, d,
                  ($urandom_range(0, 7) == 0),
                  ($urandom_range(0, 3) == 0),
                  1'($urandom));
        end
        idle("R1");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

endmodule